// File: doc/BRIEF.md
# Sine-Fit SNDR Evaluator

This block grades the dynamic quality of an ADC test response. It takes decimated signed samples from the converter under test, together with a valid strobe and a marker that flags the first sample of each stimulus period. From these it accumulates moment sums over a fixed, power-of-two number of samples. Meanwhile an internal sine reference, locked to the period marker, runs in step with the stimulus. At the end of the window it solves for the response's DC level and its fitted sine amplitude. It then forms the residual (noise plus distortion) power that remains after the DC and the amplitude-scaled reference are removed.

A controller loads two registers: the reference amplitude used in the residual, and an integer power-ratio threshold. The pass flag compares signal power against threshold times residual power, and no divider is needed for this. A start pulse arms a measurement. Accumulation begins at the next valid sample that carries the period marker. A one-cycle done pulse marks fresh results, which then hold until the next measurement completes.

Top module: `sndr_fit_eval`

## Requirements
- R1: After reset, `done` and `pass` are 0, `dc_lvl`, `amp_fit` and `err_pwr` are 0, and both loaded registers hold 0.
- R2: A `start` pulse arms the block. Samples before the first valid sample with `period_mark` = 1 are not counted. Cycles with `smp_valid` = 0 are never counted, whatever `smp_data` holds. Exactly N = 2^LOG2N valid samples are counted.
- R3: The unit reference for a counted sample at phase p (0..255) is u(p) = round(32767 * sin(2*pi*(p+0.5)/256)). It is built from a 64-entry quarter table by mirror and sign. Phase is 0 on a sample with `period_mark` = 1 and advances by one per valid sample, modulo 256.
- R4: `dc_lvl` = Sx >>> LOG2N (arithmetic shift), where Sx is the sum of the counted samples.
- R5: `amp_fit` = Sxu >>> (LOG2N+14), where Sxu = sum of x*u(p). This is the correlation divided by the nominal reference energy N*2^29.
- R6: With A the loaded reference amplitude (unsigned), `err_pwr` = (Sxx - ((2*A*Sxu) >>> 15) + ((A*A*Suu) >>> 30) - ((Sx*Sx) >>> LOG2N)) >>> LOG2N. Here Sxx = sum of x^2 and Suu = sum of u^2. A negative result gives 0, and a result above 2^34-1 saturates.
- R7: `pass` = ((A*A) >> 1) >= T * `err_pwr`, where T is the loaded threshold (unsigned).
- R8: `done` is high for exactly one cycle, two clock edges after the edge that takes the N-th counted sample. All result outputs change only on that edge and hold otherwise.
- R9: A write to either loaded register on the same edge that takes the N-th counted sample is used by that result.
- R10: When `err_pwr` is 0, `pass` is 1 for any threshold.
- R11: `ref_wr` loads `ref_data` and `thr_wr` loads `thr_data` on the clock edge where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arms a new measurement, clears sums |
| ref_wr | input | 1 | Load strobe for reference amplitude |
| ref_data | input | XW | Reference amplitude, unsigned |
| thr_wr | input | 1 | Load strobe for threshold |
| thr_data | input | TW | Power-ratio threshold, unsigned |
| smp_valid | input | 1 | Sample strobe |
| period_mark | input | 1 | First sample of a stimulus period |
| smp_data | input | XW | Signed decimated ADC sample |
| dc_lvl | output | XW | Estimated DC level, signed |
| amp_fit | output | XW+1 | Fitted amplitude, signed |
| err_pwr | output | 2*XW+2 | Residual noise-plus-distortion power |
| pass | output | 1 | Pass flag |
| done | output | 1 | One-cycle results-valid strobe |

## Verification
Two functions can coincide in one cycle: the final counted sample entering the sums, and a threshold load from the controller. The bench raises `thr_wr` with a strict threshold in the very cycle it drives the N-th sample, after the measurement was started with a threshold of zero. The result is judged correct only if the pass flag follows the new threshold, and the bench's own model predicts the flag from the late value. The done pulse is checked for its exact edge in the same run.

// File: rtl/sndr_pkg.sv
// Shared types and elaboration-time helpers for the SNDR evaluator.
// Assumes the quarter table spans a quarter period with a half-sample offset.
package sndr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_ACC,
        ST_FIN
    } eval_st_t;

    // Quarter-table entry k, scaled to full signed range of uw bits.
    function automatic int quarter_sine(input int k, input int uw, input int qb);
        real ang;
        ang = 2.0 * 3.141592653589793 * (real'(k) + 0.5) / real'(4 << qb);
        return int'(real'((1 << (uw - 1)) - 1) * $sin(ang));
    endfunction

endpackage

// File: rtl/sndr_sine_ref.sv
// Unit sine reference: folds a quarter table by mirror and sign.
// Assumes phase is QB+2 bits; the top two bits pick the quadrant.
module sndr_sine_ref #(
    parameter int UW = 16,
    parameter int QB = 6
) (
    input  logic [QB+1:0]         phase,
    output logic signed [UW-1:0]  u
);
    localparam int ENT = 1 << QB;

    logic [UW-1:0] tbl [ENT];
    logic [QB-1:0] idx;
    logic [UW-1:0] mag;

    for (genvar g = 0; g < ENT; g++) begin : g_tbl
        assign tbl[g] = UW'(sndr_pkg::quarter_sine(g, UW, QB));
    end

    // Mirror in odd quadrants, negate in the lower half period.
    always_comb begin
        idx = phase[QB] ? ~phase[QB-1:0] : phase[QB-1:0];
        mag = tbl[idx];
        u   = phase[QB+1] ? -signed'(mag) : signed'(mag);
    end

endmodule

// File: rtl/sndr_fit_accum.sv
// Moment accumulator: running sums of x, x*x, x*u and u*u.
// Assumes widths are sized so 2^LN samples never overflow.
module sndr_fit_accum #(
    parameter int XW = 16,
    parameter int UW = 16,
    parameter int LN = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       acc_en,
    input  logic signed [XW-1:0]       x,
    input  logic signed [UW-1:0]       u,
    output logic signed [XW+LN-1:0]    sx,
    output logic signed [2*XW+LN-1:0]  sxx,
    output logic signed [XW+UW+LN-1:0] sxu,
    output logic signed [2*UW+LN-1:0]  suu
);
    localparam int SXW = XW + LN;
    localparam int SQW = 2 * XW + LN;
    localparam int SCW = XW + UW + LN;
    localparam int SUW = 2 * UW + LN;

    logic signed [2*XW-1:0]  pxx;
    logic signed [XW+UW-1:0] pxu;
    logic signed [2*UW-1:0]  puu;

    // Per-sample products at full width.
    always_comb begin
        pxx = x * x;
        pxu = x * u;
        puu = u * u;
    end

    // Clear on arm, add one sample per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sx  <= '0;
            sxx <= '0;
            sxu <= '0;
            suu <= '0;
        end else if (acc_en) begin
            sx  <= sx  + SXW'(x);
            sxx <= sxx + SQW'(pxx);
            sxu <= sxu + SCW'(pxu);
            suu <= suu + SUW'(puu);
        end
    end

endmodule

// File: rtl/sndr_fit_solve.sv
// Closed-form solve of DC, amplitude, residual power and pass flag.
// Assumes whole stimulus periods were summed, so the reference sums to zero.
module sndr_fit_solve #(
    parameter int XW = 16,
    parameter int UW = 16,
    parameter int TW = 16,
    parameter int LN = 12
) (
    input  logic signed [XW+LN-1:0]    sx,
    input  logic signed [2*XW+LN-1:0]  sxx,
    input  logic signed [XW+UW+LN-1:0] sxu,
    input  logic signed [2*UW+LN-1:0]  suu,
    input  logic [XW-1:0]              ref_amp,
    input  logic [TW-1:0]              thr,
    output logic signed [XW-1:0]       dc,
    output logic signed [XW:0]         amp,
    output logic [2*XW+1:0]            err,
    output logic                       pass
);
    localparam int EW = 2 * XW + 2;
    localparam int WW = 2 * XW + 2 * UW + LN + 4;
    localparam int PW = TW + EW;
    localparam logic signed [WW-1:0] EMAX = (WW'(1) <<< EW) - WW'(1);

    logic signed [WW-1:0] a_w, sx_w, sxx_w, sxu_w, suu_w;
    logic signed [WW-1:0] t_xu, t_uu, t_dc, tot, e_w;
    logic [2*XW-1:0]      asq;
    logic [PW-1:0]        prod;

    // Expand the residual energy from the moments, then normalise.
    always_comb begin
        a_w   = WW'(signed'({1'b0, ref_amp}));
        sx_w  = WW'(sx);
        sxx_w = WW'(sxx);
        sxu_w = WW'(sxu);
        suu_w = WW'(suu);
        t_xu  = (sxu_w * a_w * 2) >>> (UW - 1);
        t_uu  = (a_w * a_w * suu_w) >>> (2 * (UW - 1));
        t_dc  = (sx_w * sx_w) >>> LN;
        tot   = sxx_w - t_xu + t_uu - t_dc;
        e_w   = tot >>> LN;
        if (e_w < 0)         err = '0;
        else if (e_w > EMAX) err = '1;
        else                 err = EW'(e_w);
    end

    // Means by shift and a division-free ratio compare.
    always_comb begin
        dc   = XW'(sx >>> LN);
        amp  = (XW + 1)'(sxu >>> (LN + UW - 2));
        asq  = ref_amp * ref_amp;
        prod = thr * err;
        pass = PW'(asq >> 1) >= prod;
    end

endmodule

// File: rtl/sndr_fit_eval.sv
// Top of the SNDR evaluator: sequencing, phase tracking, loaded registers
// and result registers. Assumes 2^LOG2N is a whole number of periods.
module sndr_fit_eval #(
    parameter int XW    = 16,
    parameter int UW    = 16,
    parameter int TW    = 16,
    parameter int LOG2N = 12,
    parameter int QB    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 ref_wr,
    input  logic [XW-1:0]        ref_data,
    input  logic                 thr_wr,
    input  logic [TW-1:0]        thr_data,
    input  logic                 smp_valid,
    input  logic                 period_mark,
    input  logic signed [XW-1:0] smp_data,
    output logic signed [XW-1:0] dc_lvl,
    output logic signed [XW:0]   amp_fit,
    output logic [2*XW+1:0]      err_pwr,
    output logic                 pass,
    output logic                 done
);
    import sndr_pkg::*;

    localparam int PHW = QB + 2;
    localparam int EW  = 2 * XW + 2;

    eval_st_t                    st;
    logic [LOG2N-1:0]            cnt;
    logic [PHW-1:0]              ph_q, ph_now;
    logic [XW-1:0]               ref_amp;
    logic [TW-1:0]               thr;
    logic                        acc_en;
    logic signed [UW-1:0]        u;
    logic signed [XW+LOG2N-1:0]    sx;
    logic signed [2*XW+LOG2N-1:0]  sxx;
    logic signed [XW+UW+LOG2N-1:0] sxu;
    logic signed [2*UW+LOG2N-1:0]  suu;
    logic signed [XW-1:0]        s_dc;
    logic signed [XW:0]          s_amp;
    logic [EW-1:0]               s_err;
    logic                        s_pass;

    // Phase seen by the current sample, and accumulate qualification.
    always_comb begin
        ph_now = period_mark ? '0 : ph_q;
        acc_en = !start && smp_valid &&
                 ((st == ST_ARM && period_mark) || st == ST_ACC);
    end

    // Phase counter advances once per valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n)         ph_q <= '0;
        else if (smp_valid) ph_q <= ph_now + PHW'(1);
    end

    // Controller-loaded reference amplitude and threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_amp <= '0;
            thr     <= '0;
        end else begin
            if (ref_wr) ref_amp <= ref_data;
            if (thr_wr) thr     <= thr_data;
        end
    end

    // Measurement sequencer and sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (start) begin
            st  <= ST_ARM;
            cnt <= '0;
        end else begin
            case (st)
                ST_ARM: if (smp_valid && period_mark) begin
                    st  <= ST_ACC;
                    cnt <= LOG2N'(1);
                end
                ST_ACC: if (smp_valid) begin
                    cnt <= cnt + LOG2N'(1);
                    if (cnt == '1) st <= ST_FIN;
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Result registers capture the solve once per measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_lvl  <= '0;
            amp_fit <= '0;
            err_pwr <= '0;
            pass    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= (st == ST_FIN);
            if (st == ST_FIN) begin
                dc_lvl  <= s_dc;
                amp_fit <= s_amp;
                err_pwr <= s_err;
                pass    <= s_pass;
            end
        end
    end

    sndr_sine_ref #(.UW(UW), .QB(QB)) u_ref (
        .phase (ph_now),
        .u     (u)
    );

    sndr_fit_accum #(.XW(XW), .UW(UW), .LN(LOG2N)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start),
        .acc_en (acc_en),
        .x      (smp_data),
        .u      (u),
        .sx     (sx),
        .sxx    (sxx),
        .sxu    (sxu),
        .suu    (suu)
    );

    sndr_fit_solve #(.XW(XW), .UW(UW), .TW(TW), .LN(LOG2N)) u_solve (
        .sx      (sx),
        .sxx     (sxx),
        .sxu     (sxu),
        .suu     (suu),
        .ref_amp (ref_amp),
        .thr     (thr),
        .dc      (s_dc),
        .amp     (s_amp),
        .err     (s_err),
        .pass    (s_pass)
    );

endmodule

// File: rtl/sndr_fit_chk.sv
// Temporal checks on the evaluator's result interface, bound to the top.
module sndr_fit_chk #(
    parameter int XW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 smp_valid,
    input logic                 done,
    input logic                 pass,
    input logic [2*XW+1:0]      err_pwr,
    input logic signed [XW-1:0] dc_lvl,
    input logic signed [XW:0]   amp_fit
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(smp_valid, 2)); // R8

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pass) && $stable(err_pwr) &&
                   $stable(dc_lvl) && $stable(amp_fit))); // R8

    AST_ZERO_ERR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_pwr == '0) |-> pass); // R10

endmodule

bind sndr_fit_eval sndr_fit_chk #(.XW(XW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .done      (done),
    .pass      (pass),
    .err_pwr   (err_pwr),
    .dc_lvl    (dc_lvl),
    .amp_fit   (amp_fit)
);

// File: tb/sim_sndr_fit_eval.sv
module sim_sndr_fit_eval;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4096;
    localparam int NV         = 5;
    // amp, dc, noise, ref amplitude, threshold
    localparam int VEC [NV][5] = '{
        '{10000,    0,   0, 10000,   100},
        '{ 8000,  500,  50,  8000,  1000},
        '{12000, -300, 400, 12000, 50000},
        '{ 5000,  100,  20,  6000,    10},
        '{    0, 1000,   0,     0,     5}
    };

    logic clk = 0, rst_n = 0, start = 0, ref_wr = 0, thr_wr = 0;
    logic smp_valid = 0, period_mark = 0;
    logic [15:0] ref_data = 0, thr_data = 0;
    logic signed [15:0] smp_data = 0;
    logic signed [15:0] dc_lvl;
    logic signed [16:0] amp_fit;
    logic [33:0] err_pwr;
    logic pass, done;

    int checks = 0, errors = 0;
    longint e_dc, e_amp, e_err;
    bit e_pass, done_ok;

    always #(CLK_PERIOD/2) clk = ~clk;

    sndr_fit_eval u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_wr(ref_wr),
        .ref_data(ref_data), .thr_wr(thr_wr), .thr_data(thr_data),
        .smp_valid(smp_valid), .period_mark(period_mark), .smp_data(smp_data),
        .dc_lvl(dc_lvl), .amp_fit(amp_fit), .err_pwr(err_pwr),
        .pass(pass), .done(done)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_u(input int p);
        return int'(32767.0 * $sin(2.0 * 3.141592653589793 * (real'(p) + 0.5) / 256.0));
    endfunction

    // One measurement; th_last >= 0 loads a threshold with the final sample.
    task automatic run_meas(input int amp, input int dc, input int nz, input int ra,
                            input int th, input bit gaps, input int th_last);
        logic signed [127:0] sx, sxx, sxu, suu, a, t, e;
        int x, u, nse, th_use;
        sx = 0; sxx = 0; sxu = 0; suu = 0;
        @(negedge clk);
        ref_wr = 1; ref_data = 16'(ra); thr_wr = 1; thr_data = 16'(th);
        @(negedge clk);
        ref_wr = 0; thr_wr = 0; start = 1;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 3; k++) begin          // R2 unmarked preamble
            smp_valid = 1; period_mark = 0; smp_data = 16'sd20000;
            @(negedge clk);
        end
        for (int n = 0; n < N; n++) begin
            if (gaps && (n % 7 == 3)) begin       // R2 invalid cycles
                smp_valid = 0; period_mark = 1; smp_data = -16'sd30000;
                @(negedge clk);
            end
            u   = ref_u(n % 256);
            nse = (nz > 0) ? ((n * 37 + 11) % (2 * nz + 1)) - nz : 0;
            x   = ((amp * u) >>> 15) + dc + nse;
            smp_valid = 1; period_mark = (n % 256 == 0); smp_data = 16'(x);
            if (n == N - 1 && th_last >= 0) begin thr_wr = 1; thr_data = 16'(th_last); end
            sx += x; sxx += x * x; sxu += longint'(x) * u; suu += longint'(u) * u;
            @(negedge clk);
        end
        smp_valid = 0; period_mark = 0; thr_wr = 0;
        th_use = (th_last >= 0) ? th_last : th;
        a = ra;
        t = sxx - ((sxu * a * 2) >>> 15) + ((a * a * suu) >>> 30) - ((sx * sx) >>> 12);
        e = t >>> 12;
        if (e < 0) e = 0;
        if (e > 128'sd17179869183) e = 128'sd17179869183;
        e_err  = longint'(e);
        e_dc   = longint'(sx >>> 12);
        e_amp  = longint'(sxu >>> 26);
        e_pass = ((longint'(ra) * ra) >> 1) >= longint'(th_use) * e_err;
        done_ok = (done == 0);                      // one edge after last sample
        @(negedge clk);
        done_ok = done_ok && (done == 1);           // R8 second edge
        check(done_ok, "R8 done timing", done, 1);
    endtask

    task automatic check_results(input string tag);
        check(dc_lvl == e_dc, {"R4 dc ", tag}, dc_lvl, e_dc);
        check(amp_fit == e_amp, {"R5 R3 amplitude ", tag}, amp_fit, e_amp);
        check(err_pwr == e_err, {"R6 error power ", tag}, err_pwr, e_err);
        check(pass == e_pass, {"R7 R11 pass ", tag}, pass, e_pass);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        longint ps, e2, tb;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(done == 0 && pass == 0, "R1 flags after reset", {done, pass}, 0);
        check(dc_lvl == 0 && amp_fit == 0 && err_pwr == 0, "R1 results after reset", err_pwr, 0);

        for (int v = 0; v < NV; v++) begin
            run_meas(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], v == 1, -1);
            check_results($sformatf("vec%0d", v));
            if (v == 4) check(pass == 1 && err_pwr == 0, "R10 zero error passes", pass, 1);
            @(negedge clk);
            check(done == 0, "R8 done single cycle", done, 0);
        end

        // R7 boundary: threshold equal to floor(Ps/err) passes, one more fails
        run_meas(8000, 500, 50, 8000, 0, 0, -1);
        ps = (64'd8000 * 8000) >> 1;
        e2 = e_err;
        tb = (e2 > 0) ? ps / e2 : 65534;
        if (tb > 65534) tb = 65534;
        run_meas(8000, 500, 50, 8000, int'(tb), 0, -1);
        check_results("boundary");
        check(pass == 1, "R7 at boundary", pass, 1);
        run_meas(8000, 500, 50, 8000, int'(tb) + 1, 0, -1);
        check(pass == e_pass, "R7 past boundary", pass, e_pass);
        check(e2 == 0 || tb == 65534 || pass == 0, "R7 past boundary fails", pass, 0);

        // R9 threshold written with the final sample takes effect
        run_meas(12000, -300, 400, 12000, 0, 0, 65535);
        check_results("late threshold");
        check(pass == 0, "R9 late threshold used", pass, 0);

        // R10 zero residual with maximum threshold
        run_meas(0, -700, 0, 0, 65535, 0, -1);
        check(err_pwr == 0 && pass == 1, "R10 zero error max threshold", pass, 1);
        check(dc_lvl == -700, "R4 negative dc", dc_lvl, -700);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule